// File: doc/BRIEF.md
# Serial Block-Write Configuration Register Bank

This block is the slave-side register bank of a clock generator's configuration port. It sits behind a two-wire SMBus-style serial link whose pad logic has already filtered and synchronised the line. That logic hands the block one-cycle event strobes: start or repeated start, stop, each SCL rising edge with the SDA level sampled at that edge, and each SCL falling edge. The block answers on SDA through a single pull-low output. It holds twenty-one configuration bytes and presents all of them at once on a flat parallel bus.

A write transaction is always a block write. After the address byte come a command byte and a count byte. The block acknowledges both and discards them. Every byte after that lands in the next register, starting at register 0, until the master ends the transfer. Register 7 is a fixed identification byte. Registers 11/12 and 13/14 are two pairs that only ever change together. Register 8 holds the number of bytes a read returns. A read shifts out registers from register 0 upward, MSB first.

Top module: `smbcfg_top`

## Requirements
- R1: After reset, register 8 reads 08h, register 9 reads 10h, register 7 reads {4'b1001, REV}, and every other register reads 00h. Register i appears on cfg_flat[8i+7:8i].
- R2: In an address byte, the first seven bits (MSB first) are the address and the eighth bit is read (1) or write (0). When the address equals SLV_ADDR, sda_low is high in the ninth bit slot. For any other address, sda_low stays low until the next start.
- R3: In a write, the first two bytes after the address are acknowledged and leave every register unchanged.
- R4: The third and later bytes of a write go to registers 0, 1, 2 and upward in that order. A transfer may end after any whole byte. Bytes beyond the last register are acknowledged and dropped.
- R5: Register 7 is read-only. Writes to it are acknowledged and have no effect.
- R6: Registers 11 and 12 change only when byte 12 arrives in the same transaction as byte 11; the same rule holds for registers 13 and 14. A low byte whose partner has not arrived is discarded at a stop or a repeated start.
- R7: A write of 00h to register 8 is ignored, so register 8 is never zero.
- R8: A read returns register 0 onward, MSB first. It returns as many bytes as register 8 holds. Once that count is reached, or when the master NACKs, sda_low stays low and the master reads FFh.
- R9: Every byte the block receives in a write to its own address is acknowledged: sda_low is high in that byte's ninth bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset to register defaults |
| ev_start | input | 1 | Strobe: start or repeated start seen on the bus |
| ev_stop | input | 1 | Strobe: stop seen on the bus |
| ev_rise | input | 1 | Strobe: SCL rising edge; sda_in is sampled here |
| ev_fall | input | 1 | Strobe: SCL falling edge; the slave updates its SDA drive |
| sda_in | input | 1 | Resolved SDA level at the rising edge |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_flat | output | NREG*8 | All registers; register i at bits [8i+7:8i] |

## Verification
On every cycle, the assertions check three things. Register 8 never holds zero, and a zero written to it leaves it unchanged. The header bytes never alter the register bus. Each register pair stays unchanged on every cycle except its commit cycle. They also check that SDA is released after a stop. Other behaviour depends on whole transactions and only the bench's scenarios can show it. This covers the ascending fill order, the discard of a lone pair byte at a repeated start, the bit order and length of a readback, early termination by NACK, and the silence on a foreign address.

// File: rtl/smbcfg_pkg.sv
`timescale 1ns/1ps
package smbcfg_pkg;
  localparam int ID_IDX  = 7;
  localparam int LEN_IDX = 8;
  localparam logic [3:0] VENDOR = 4'b1001;

  typedef enum logic [2:0] {L_IDLE, L_ADDR, L_WR, L_RD, L_SKIP} link_st_e;

  // first byte of pair p
  function automatic int pair_base(int p);
    return (p == 0) ? 11 : 13;
  endfunction

  function automatic bit is_pair_lo(int i);
    return (i == 11) || (i == 13);
  endfunction

  function automatic bit is_pair_hi(int i);
    return (i == 12) || (i == 14);
  endfunction

  function automatic int pair_of(int i);
    return (i >= 13) ? 1 : 0;
  endfunction

  function automatic logic [7:0] cfg_default(int i);
    case (i)
      8:       return 8'h08;
      9:       return 8'h10;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smbcfg_link.sv
`timescale 1ns/1ps
module smbcfg_link
  import smbcfg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_rise,
  input  logic       ev_fall,
  input  logic       sda_in,
  input  logic [7:0] tx_byte,
  input  logic [7:0] rd_len,
  output logic       sda_low,
  output logic       wr_stb,
  output logic [7:0] wr_pos,
  output logic [7:0] wr_data,
  output logic [7:0] rd_idx
);
  link_st_e   st;
  logic [3:0] bcnt;      // rising edges seen in the current 9-bit slot group
  logic [6:0] shreg;
  logic       addr_hit, rd_req, tx_on;
  logic [7:0] wr_cnt;

  assign wr_stb  = ev_rise && (st == L_WR) && (bcnt == 4'd7);
  assign wr_data = {shreg, sda_in};
  assign wr_pos  = wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; bcnt <= '0; shreg <= '0; addr_hit <= 1'b0; rd_req <= 1'b0;
      tx_on <= 1'b0; wr_cnt <= '0; rd_idx <= '0; sda_low <= 1'b0;
    end else if (ev_start) begin
      st <= L_ADDR; bcnt <= '0; sda_low <= 1'b0; tx_on <= 1'b0;
    end else if (ev_stop) begin
      st <= L_IDLE; bcnt <= '0; sda_low <= 1'b0; tx_on <= 1'b0;
    end else if (ev_rise && st != L_IDLE) begin
      bcnt <= (bcnt == 4'd8) ? 4'd0 : bcnt + 4'd1;
      if (bcnt != 4'd8) shreg <= {shreg[5:0], sda_in};
      case (st)
        L_ADDR: begin
          if (bcnt == 4'd7) begin
            addr_hit <= (shreg == SLV_ADDR);
            rd_req   <= sda_in;
          end else if (bcnt == 4'd8) begin
            st     <= !addr_hit ? L_SKIP : (rd_req ? L_RD : L_WR);
            wr_cnt <= '0;
            rd_idx <= '0;
            tx_on  <= addr_hit && rd_req && (rd_len != 8'd0);
          end
        end
        L_WR: if (bcnt == 4'd7 && wr_cnt != 8'hFF) wr_cnt <= wr_cnt + 8'd1;
        L_RD: if (bcnt == 4'd8) begin
          if (!sda_in && tx_on) begin
            rd_idx <= rd_idx + 8'd1;
            tx_on  <= ({1'b0, rd_idx} + 9'd1) < {1'b0, rd_len};
          end else begin
            tx_on <= 1'b0;
          end
        end
        default: ;
      endcase
    end else if (ev_fall) begin
      case (st)
        L_ADDR:  sda_low <= (bcnt == 4'd8) && addr_hit;
        L_WR:    sda_low <= (bcnt == 4'd8);
        L_RD:    sda_low <= (bcnt < 4'd8) && tx_on && !tx_byte[3'd7 - bcnt[2:0]];
        default: sda_low <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/smbcfg_regs.sv
`timescale 1ns/1ps
module smbcfg_regs
  import smbcfg_pkg::*;
#(
  parameter int         NREG = 21,
  parameter logic [3:0] REV  = 4'h2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [7:0]      wr_pos,
  input  logic [7:0]      wr_data,
  input  logic            xfer_end,
  input  logic [7:0]      rd_idx,
  output logic [NREG*8-1:0] cfg_flat,
  output logic [7:0]      tx_byte,
  output logic [7:0]      rd_len,
  output logic [1:0]      pair_commit
);
  localparam int HDR = 2;

  logic [7:0] slot;
  logic       data_ok;
  logic [7:0] stage [2];
  logic [1:0] held;

  assign slot    = wr_pos - 8'(HDR);
  assign data_ok = wr_stb && (wr_pos >= 8'(HDR)) && (32'(slot) < NREG);

  for (genvar p = 0; p < 2; p++) begin : g_pair
    assign pair_commit[p] = data_ok && (32'(slot) == pair_base(p) + 1) && held[p];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held[p] <= 1'b0; stage[p] <= '0;
      end else if (xfer_end) begin
        held[p] <= 1'b0;
      end else if (data_ok && 32'(slot) == pair_base(p)) begin
        held[p] <= 1'b1; stage[p] <= wr_data;
      end else if (data_ok && 32'(slot) == pair_base(p) + 1) begin
        held[p] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == ID_IDX) begin : g_id
      assign cfg_flat[8*i +: 8] = {VENDOR, REV};
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= cfg_default(i);
        else if (is_pair_lo(i)) begin
          if (pair_commit[pair_of(i)]) q <= stage[pair_of(i)];
        end else if (is_pair_hi(i)) begin
          if (pair_commit[pair_of(i)]) q <= wr_data;
        end else if (data_ok && 32'(slot) == i && !(i == LEN_IDX && wr_data == 8'h00)) begin
          q <= wr_data;
        end
      end
      assign cfg_flat[8*i +: 8] = q;
    end
  end

  assign tx_byte = (32'(rd_idx) < NREG) ? cfg_flat[{rd_idx, 3'b000} +: 8] : 8'hFF;
  assign rd_len  = cfg_flat[8*LEN_IDX +: 8];
endmodule

// File: rtl/smbcfg_top.sv
`timescale 1ns/1ps
module smbcfg_top #(
  parameter int         NREG     = 21,
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter logic [3:0] REV      = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              sda_in,
  output logic              sda_low,
  output logic [NREG*8-1:0] cfg_flat
);
  logic       wr_stb;
  logic [7:0] wr_pos, wr_data, rd_idx, tx_byte, rd_len;
  logic [1:0] pair_commit;
  logic       xfer_end;

  assign xfer_end = ev_start || ev_stop;

  smbcfg_link #(.SLV_ADDR(SLV_ADDR)) u_link (
    .clk, .rst_n, .ev_start, .ev_stop, .ev_rise, .ev_fall, .sda_in,
    .tx_byte, .rd_len, .sda_low, .wr_stb, .wr_pos, .wr_data, .rd_idx
  );

  smbcfg_regs #(.NREG(NREG), .REV(REV)) u_regs (
    .clk, .rst_n, .wr_stb, .wr_pos, .wr_data, .xfer_end, .rd_idx,
    .cfg_flat, .tx_byte, .rd_len, .pair_commit
  );
endmodule

// File: rtl/smbcfg_chk.sv
`timescale 1ns/1ps
module smbcfg_chk #(
  parameter int NREG = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_stop,
  input logic              sda_low,
  input logic              wr_stb,
  input logic [7:0]        wr_pos,
  input logic [7:0]        wr_data,
  input logic [1:0]        pair_commit,
  input logic [7:0]        rd_len,
  input logic [NREG*8-1:0] cfg_flat
);
  // R7
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_len != 8'h00);

  // R7
  len_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_pos == 8'd10 && wr_data == 8'h00) |=> $stable(rd_len));

  // R3
  hdr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_pos < 8'd2) |=> $stable(cfg_flat));

  // R6
  pair_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_commit[0] |=> $stable(cfg_flat[8*11 +: 16]));

  // R6
  pair_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_commit[1] |=> $stable(cfg_flat[8*13 +: 16]));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_low);
endmodule

bind smbcfg_top smbcfg_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .sda_low(sda_low),
  .wr_stb(wr_stb), .wr_pos(wr_pos), .wr_data(wr_data),
  .pair_commit(pair_commit), .rd_len(rd_len), .cfg_flat(cfg_flat)
);

// File: tb/test_smbcfg_top.sv
`timescale 1ns/1ps
module test_smbcfg_top;
  localparam int         NREG = 21;
  localparam logic [6:0] ADDR = 7'h69;
  localparam logic [3:0] REV  = 4'h2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 1'b0, ev_stop = 1'b0, ev_rise = 1'b0, ev_fall = 1'b0, sda_in = 1'b1;
  logic sda_low;
  logic [NREG*8-1:0] cfg_flat;

  int vectors = 0, fails = 0;
  logic [7:0] exp_r [NREG];
  logic [7:0] wbuf [32];
  bit any_low;

  always #2.5 clk = ~clk;

  smbcfg_top #(.NREG(NREG), .SLV_ADDR(ADDR), .REV(REV)) i_smbcfg_top (
    .clk, .rst_n, .ev_start, .ev_stop, .ev_rise, .ev_fall, .sda_in, .sda_low, .cfg_flat
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] dflt(int i);
    if (i == 7) return {4'b1001, REV};
    if (i == 8) return 8'h08;
    if (i == 9) return 8'h10;
    return 8'h00;
  endfunction

  // applies n data bytes of wbuf under the register rules
  function automatic void model_apply(int n);
    logic [7:0] lo [2];
    bit has [2];
    has[0] = 0; has[1] = 0; lo[0] = 0; lo[1] = 0;
    for (int k = 0; k < n; k++) begin
      if (k >= NREG || k == 7) continue;
      if (k == 8 && wbuf[k] == 8'h00) continue;
      if (k == 11 || k == 13) begin lo[k == 13] = wbuf[k]; has[k == 13] = 1; end
      else if (k == 12 || k == 14) begin
        if (has[k == 14]) begin exp_r[k-1] = lo[k == 14]; exp_r[k] = wbuf[k]; end
      end
      else exp_r[k] = wbuf[k];
    end
  endfunction

  function automatic logic [7:0] exp_read(int j);
    if (j >= int'(exp_r[8]) || j >= NREG) return 8'hFF;
    return exp_r[j];
  endfunction

  task automatic cmp_all(input string req);
    for (int i = 0; i < NREG; i++)
      check(cfg_flat[8*i +: 8] === exp_r[i], req, cfg_flat[8*i +: 8], exp_r[i]);
  endtask

  task automatic pulse_fall;  @(negedge clk) ev_fall = 1;  @(negedge clk) ev_fall = 0;  endtask
  task automatic pulse_start; @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0; endtask
  task automatic pulse_stop;  @(negedge clk) ev_stop = 1;  @(negedge clk) ev_stop = 0;  endtask

  task automatic slot(input bit mb, output bit line);
    pulse_fall();
    any_low |= sda_low;
    line = mb & ~sda_low;
    @(negedge clk) begin sda_in = line; ev_rise = 1; end
    @(negedge clk) begin ev_rise = 0; sda_in = 1; end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit l;
    for (int i = 7; i >= 0; i--) slot(b[i], l);
    slot(1'b1, l);
    ack = !l;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    bit l;
    for (int i = 0; i < 8; i++) begin slot(1'b1, l); b = {b[6:0], l}; end
    slot(mack, l);
  endtask

  // block write of n data bytes; end_mode 0 = stop, 1 = leave for repeated start
  task automatic write_txn(input int n, input int end_mode);
    bit ack;
    pulse_start();
    send_byte({ADDR, 1'b0}, ack); check(ack, "R2 addr ack", 8'(ack), 8'h01);
    send_byte(8'($urandom), ack); check(ack, "R3 cmd ack", 8'(ack), 8'h01);
    send_byte(8'($urandom), ack); check(ack, "R3 cnt ack", 8'(ack), 8'h01);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); check(ack, "R9 data ack", 8'(ack), 8'h01);
    end
    model_apply(n);
    pulse_fall();
    if (end_mode == 0) pulse_stop();
  endtask

  // read k bytes, NACK on the last one (or ACK all when ack_last)
  task automatic read_txn(input int k, input bit ack_last, input string req);
    bit ack;
    logic [7:0] b;
    pulse_start();
    send_byte({ADDR, 1'b1}, ack); check(ack, "R2 read addr ack", 8'(ack), 8'h01);
    for (int j = 0; j < k; j++) begin
      recv_byte((j == k - 1) ? !ack_last : 1'b0, b);
      check(b === exp_read(j), req, b, exp_read(j));
    end
    pulse_fall();
    pulse_stop();
  endtask

  task automatic fill_rand(int n);
    for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'd1357));
    for (int i = 0; i < NREG; i++) exp_r[i] = dflt(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_all("R1 reset");

    // R5: write over the identification byte
    fill_rand(8); wbuf[7] = 8'h00; wbuf[6] = 8'hA5;
    write_txn(8, 0); cmp_all("R5 id readonly");

    // R7: zero to length byte ignored, nonzero accepted
    fill_rand(9); wbuf[7] = 8'h33; wbuf[8] = 8'h00;
    write_txn(9, 0); cmp_all("R7 zero len ignored");
    check(cfg_flat[8*8 +: 8] === 8'h08, "R7 len kept", cfg_flat[8*8 +: 8], 8'h08);
    fill_rand(9); wbuf[8] = 8'h06;
    write_txn(9, 0); cmp_all("R7 len write");

    // R8: read past the count -> FF; early NACK releases
    read_txn(9, 1'b1, "R8 readback count");
    pulse_start();
    send_byte({ADDR, 1'b1}, ack); check(ack, "R2 read addr ack", 8'(ack), 8'h01);
    recv_byte(1'b0, b); check(b === exp_r[0], "R8 byte0", b, exp_r[0]);
    recv_byte(1'b1, b); check(b === exp_r[1], "R8 byte1", b, exp_r[1]);
    recv_byte(1'b1, b); check(b === 8'hFF, "R8 after nack", b, 8'hFF);
    pulse_fall(); pulse_stop();

    // R6: lone low byte of a pair at stop, then at repeated start
    fill_rand(12); wbuf[8] = 8'h06;
    write_txn(12, 0); cmp_all("R6 lone byte stop");
    fill_rand(14); wbuf[8] = 8'h06;
    write_txn(14, 1);
    fill_rand(3);
    write_txn(3, 0); cmp_all("R6 lone byte restart");
    check(cfg_flat[8*13 +: 8] === exp_r[13], "R6 pair b low", cfg_flat[8*13 +: 8], exp_r[13]);
    fill_rand(15); wbuf[8] = 8'h06;
    write_txn(15, 0); cmp_all("R6 both pairs commit");

    // R4: beyond last register
    fill_rand(25); wbuf[8] = 8'h17;
    write_txn(25, 0); cmp_all("R4 overrun ignored");
    read_txn(24, 1'b1, "R8 read beyond regs");

    // R2: foreign address
    pulse_start();
    any_low = 0;
    send_byte({7'h2A, 1'b0}, ack); check(!ack, "R2 foreign nack", 8'(ack), 8'h00);
    for (int k = 0; k < 6; k++) send_byte(8'h00, ack);
    check(!any_low, "R2 foreign silent", 8'(any_low), 8'h00);
    pulse_fall(); pulse_stop();
    cmp_all("R2 foreign no write");

    // random block writes and reads
    for (int t = 0; t < 40; t++) begin
      int n = $urandom_range(0, 24);
      fill_rand(n);
      write_txn(n, int'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) pulse_start();
      pulse_fall(); pulse_stop();
      cmp_all("R4 random write");
      if ($urandom_range(0, 2) == 0) read_txn($urandom_range(1, 10), 1'b0, "R8 random read");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule